// File: doc/BRIEF.md
# PLL Reconfiguration Sequencer

This block reprograms a frequency-synthesis PLL over a simple register bus. A single-cycle start pulse hands it a ready-made 32-bit multiplier configuration word. The sequencer first reads the PLL control register. It writes that register back with power-down set and every output path and bypass switched off. It then loads the multiplier word and a fixed divider word that sets both the pre-divider and the post-divider to one. After that it clears power-down and polls the lock flag a bounded number of times, with a timed interval before every poll.

If a poll shows lock, the sequencer switches the clock output on and signals done. If the last allowed poll still shows no lock, it signals an error and leaves the output switched off. One bus access is in flight at a time, and each access waits as long as the bus needs.

Top module: `pll_reprog_seq`

## Requirements
- R1: After reset, busy_o, done_o, err_o, reg_wr_o and reg_rd_o are all low.
- R2: A start pulse while idle raises busy_o on the next cycle and captures cfg_word_i. The first bus access is a read of the control register at offset 0x20.
- R3: The second access writes the control register (0x20) with the value read, with bit 0 (power-down) set, bits 1 to 4 (bypass, input path, output path, clock-enable) cleared, and all other bits unchanged.
- R4: Next, the captured configuration word is written to offset 0x24, and then 0x00302062 is written to offset 0x28, in that order.
- R5: Next, the control register is written with the power-down value from R3 with bit 0 cleared, so that all bits 0 to 4 are zero and the other bits are as read.
- R6: Every status read (offset 0x1C) is preceded by a wait of at least CLK_FREQ_MHZ*POLL_US cycles after the previous access completes. Bit 0 of the read data is the lock flag, and no other bit affects the result.
- R7: At most MAX_POLLS (default 4) status reads are made. On the first read with bit 0 set, the control register is written with the R5 value plus bit 4 (clock-enable), and done_o pulses.
- R8: If none of the MAX_POLLS reads shows lock, err_o pulses, no further write is made, and clock-enable stays cleared.
- R9: An access holds its strobe, address and write data stable until reg_ready_i is seen high on a clock edge. The read and write strobes are never high together.
- R10: busy_o stays high from the accepted start until the cycle in which done_o or err_o pulses. Each of these pulses lasts one cycle, and they are never high together.
- R11: Start pulses that arrive while busy_o is high are ignored: the running sequence, its captured word and the single completion pulse are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse |
| cfg_word_i | input | 32 | Multiplier configuration word, sampled with start_i |
| reg_addr_o | output | ADDR_W | Register address |
| reg_wdata_o | output | 32 | Register write data |
| reg_wr_o | output | 1 | Write strobe |
| reg_rd_o | output | 1 | Read strobe |
| reg_rdata_i | input | 32 | Register read data, valid with reg_ready_i on a read |
| reg_ready_i | input | 1 | Access completes on a clock edge where this is high |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: PLL locked and output enabled |
| err_o | output | 1 | One-cycle pulse: no lock within the poll limit |

## Verification
The bench targets the lock boundaries: lock on the first poll, lock on the last allowed poll, and no lock at all. A design off by one in its poll counter would give up one poll early or make a fifth read. Status words carry random upper bits, so a design that tests the whole word instead of bit 0 would report lock falsely. Control read-back values are random, so a wrong set/clear mask in the power-down, power-up or enable writes shows in the logged write data. Random ready delays expose a design that changes its address early. A start pulse injected mid-sequence with a different word catches a design that restarts or recaptures. The bench also measures the gap before each status read to catch a shortened interval.

// File: rtl/pll_seq_pkg.sv
package pll_seq_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_RD_CTRL,
        ST_WR_PD,
        ST_WR_MULT,
        ST_WR_DIVS,
        ST_WR_PWRUP,
        ST_WAIT,
        ST_POLL,
        ST_WR_EN
    } seq_state_e;

    typedef enum logic {
        ACC_RD = 1'b0,
        ACC_WR = 1'b1
    } acc_kind_e;

    // control register bit positions
    localparam int unsigned CTL_PWRDN  = 0;
    localparam int unsigned CTL_BYPASS = 1;
    localparam int unsigned CTL_IN_DIR = 2;
    localparam int unsigned CTL_OUTDIR = 3;
    localparam int unsigned CTL_OUT_EN = 4;

    // status register lock flag position
    localparam int unsigned STS_LOCKED = 0;

    // register offsets
    localparam int unsigned OFS_STATUS = 32'h1C;
    localparam int unsigned OFS_CTRL   = 32'h20;
    localparam int unsigned OFS_MULT   = 32'h24;
    localparam int unsigned OFS_DIVS   = 32'h28;

    // divider word giving unity pre- and post-division
    localparam logic [31:0] DIVS_UNITY = 32'h0030_2062;

endpackage

// File: rtl/pll_seq_interval.sv
module pll_seq_interval #(
    parameter int unsigned CYCLES = 2000
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic start_i,
    output logic expire_o
);

    localparam int unsigned CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
    localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

    typedef struct packed {
        logic          run;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_q, tmr_d;

    always_comb begin
        tmr_d = tmr_q;
        if (start_i) begin
            tmr_d.run = 1'b1;
            tmr_d.cnt = '0;
        end else if (tmr_q.run) begin
            if (tmr_q.cnt == LAST) begin
                tmr_d.run = 1'b0;
            end else begin
                tmr_d.cnt = tmr_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign expire_o = tmr_q.run && (tmr_q.cnt == LAST);

    // R6: expiry is a single-cycle event unless re-armed
    assert_expire_pulse_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (expire_o && !start_i) |=> !expire_o);

endmodule

// File: rtl/pll_seq_busif.sv
module pll_seq_busif
    import pll_seq_pkg::*;
#(
    parameter int unsigned ADDR_W = 12,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              req_i,
    input  acc_kind_e         kind_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_wr_o,
    output logic              bus_rd_o,
    input  logic [DATA_W-1:0] bus_rdata_i,
    input  logic              bus_ready_i
);

    typedef struct packed {
        logic              active;
        logic              is_wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic              ack;
        logic [DATA_W-1:0] rdata;
    } bif_t;

    bif_t bif_q, bif_d;

    always_comb begin
        bif_d     = bif_q;
        bif_d.ack = 1'b0;
        if (!bif_q.active) begin
            if (req_i) begin
                bif_d.active = 1'b1;
                bif_d.is_wr  = (kind_i == ACC_WR);
                bif_d.addr   = addr_i;
                bif_d.wdata  = wdata_i;
            end
        end else if (bus_ready_i) begin
            bif_d.active = 1'b0;
            bif_d.ack    = 1'b1;
            if (!bif_q.is_wr) begin
                bif_d.rdata = bus_rdata_i;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            bif_q <= '0;
        end else begin
            bif_q <= bif_d;
        end
    end

    assign ack_o       = bif_q.ack;
    assign rdata_o     = bif_q.rdata;
    assign bus_addr_o  = bif_q.addr;
    assign bus_wdata_o = bif_q.wdata;
    assign bus_wr_o    = bif_q.active &&  bif_q.is_wr;
    assign bus_rd_o    = bif_q.active && !bif_q.is_wr;

    // R9: a stalled access keeps its strobe, address and data
    assert_hold_access_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((bus_wr_o || bus_rd_o) && !bus_ready_i) |=>
        ($stable(bus_wr_o) && $stable(bus_rd_o) && $stable(bus_addr_o) && $stable(bus_wdata_o)));

    // R9: never read and write at once
    assert_strobe_excl_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({bus_wr_o, bus_rd_o}));

    // R9: completion acknowledged only after a strobed, ready access
    assert_ack_source_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ((bus_wr_o || bus_rd_o) && bus_ready_i) |=> (ack_o && !bus_wr_o && !bus_rd_o));

endmodule

// File: rtl/pll_reprog_seq.sv
module pll_reprog_seq
    import pll_seq_pkg::*;
#(
    parameter int unsigned CLK_FREQ_MHZ = 200,
    parameter int unsigned POLL_US      = 10,
    parameter int unsigned MAX_POLLS    = 4,
    parameter int unsigned ADDR_W       = 12
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              start_i,
    input  logic [31:0]       cfg_word_i,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic [31:0]       reg_wdata_o,
    output logic              reg_wr_o,
    output logic              reg_rd_o,
    input  logic [31:0]       reg_rdata_i,
    input  logic              reg_ready_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              err_o
);

    localparam int unsigned WAIT_CYCLES = CLK_FREQ_MHZ * POLL_US;
    localparam int unsigned PW  = $clog2(MAX_POLLS + 1);
    localparam int unsigned WCW = $clog2(WAIT_CYCLES + 1);
    localparam logic [PW-1:0] LAST_POLL = PW'(MAX_POLLS - 1);

    localparam logic [ADDR_W-1:0] A_STATUS = ADDR_W'(OFS_STATUS);
    localparam logic [ADDR_W-1:0] A_CTRL   = ADDR_W'(OFS_CTRL);
    localparam logic [ADDR_W-1:0] A_MULT   = ADDR_W'(OFS_MULT);
    localparam logic [ADDR_W-1:0] A_DIVS   = ADDR_W'(OFS_DIVS);

    localparam logic [31:0] PATH_MASK = (32'd1 << CTL_BYPASS) | (32'd1 << CTL_IN_DIR)
                                      | (32'd1 << CTL_OUTDIR) | (32'd1 << CTL_OUT_EN);

    typedef struct packed {
        seq_state_e  state;
        logic [31:0] cfg;
        logic [31:0] ctrl;
        logic [PW-1:0] polls;
        logic        busy;
        logic        done;
        logic        err;
    } seq_t;

    seq_t seq_q, seq_d;

    logic              acc_req;
    acc_kind_e         acc_kind;
    logic [ADDR_W-1:0] acc_addr;
    logic [31:0]       acc_wdata;
    logic              acc_ack;
    logic [31:0]       acc_rdata;
    logic              tmr_start;
    logic              tmr_expire;

    always_comb begin
        seq_d      = seq_q;
        seq_d.done = 1'b0;
        seq_d.err  = 1'b0;
        acc_req    = 1'b0;
        acc_kind   = ACC_RD;
        acc_addr   = A_CTRL;
        acc_wdata  = seq_q.ctrl;

        unique case (seq_q.state)
            ST_IDLE: begin
                if (start_i) begin
                    seq_d.state = ST_RD_CTRL;
                    seq_d.cfg   = cfg_word_i;
                    seq_d.polls = '0;
                    seq_d.busy  = 1'b1;
                end
            end
            ST_RD_CTRL: begin
                acc_req = !acc_ack;
                if (acc_ack) begin
                    seq_d.ctrl = (acc_rdata | (32'd1 << CTL_PWRDN)) & ~PATH_MASK;
                    seq_d.state = ST_WR_PD;
                end
            end
            ST_WR_PD: begin
                acc_req  = !acc_ack;
                acc_kind = ACC_WR;
                if (acc_ack) begin
                    seq_d.state = ST_WR_MULT;
                end
            end
            ST_WR_MULT: begin
                acc_req   = !acc_ack;
                acc_kind  = ACC_WR;
                acc_addr  = A_MULT;
                acc_wdata = seq_q.cfg;
                if (acc_ack) begin
                    seq_d.state = ST_WR_DIVS;
                end
            end
            ST_WR_DIVS: begin
                acc_req   = !acc_ack;
                acc_kind  = ACC_WR;
                acc_addr  = A_DIVS;
                acc_wdata = DIVS_UNITY;
                if (acc_ack) begin
                    seq_d.ctrl  = seq_q.ctrl & ~(32'd1 << CTL_PWRDN);
                    seq_d.state = ST_WR_PWRUP;
                end
            end
            ST_WR_PWRUP: begin
                acc_req  = !acc_ack;
                acc_kind = ACC_WR;
                if (acc_ack) begin
                    seq_d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (tmr_expire) begin
                    seq_d.state = ST_POLL;
                end
            end
            ST_POLL: begin
                acc_req  = !acc_ack;
                acc_addr = A_STATUS;
                if (acc_ack) begin
                    seq_d.polls = seq_q.polls + 1'b1;
                    if (acc_rdata[STS_LOCKED]) begin
                        seq_d.ctrl  = seq_q.ctrl | (32'd1 << CTL_OUT_EN);
                        seq_d.state = ST_WR_EN;
                    end else if (seq_q.polls == LAST_POLL) begin
                        seq_d.state = ST_IDLE;
                        seq_d.busy  = 1'b0;
                        seq_d.err   = 1'b1;
                    end else begin
                        seq_d.state = ST_WAIT;
                    end
                end
            end
            ST_WR_EN: begin
                acc_req  = !acc_ack;
                acc_kind = ACC_WR;
                if (acc_ack) begin
                    seq_d.state = ST_IDLE;
                    seq_d.busy  = 1'b0;
                    seq_d.done  = 1'b1;
                end
            end
            default: begin
                seq_d.state = ST_IDLE;
                seq_d.busy  = 1'b0;
            end
        endcase

        tmr_start = (seq_d.state == ST_WAIT) && (seq_q.state != ST_WAIT);
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            seq_q <= '{state: ST_IDLE, default: '0};
        end else begin
            seq_q <= seq_d;
        end
    end

    pll_seq_busif #(
        .ADDR_W (ADDR_W),
        .DATA_W (32)
    ) u_busif (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .req_i       (acc_req),
        .kind_i      (acc_kind),
        .addr_i      (acc_addr),
        .wdata_i     (acc_wdata),
        .ack_o       (acc_ack),
        .rdata_o     (acc_rdata),
        .bus_addr_o  (reg_addr_o),
        .bus_wdata_o (reg_wdata_o),
        .bus_wr_o    (reg_wr_o),
        .bus_rd_o    (reg_rd_o),
        .bus_rdata_i (reg_rdata_i),
        .bus_ready_i (reg_ready_i)
    );

    pll_seq_interval #(
        .CYCLES (WAIT_CYCLES)
    ) u_interval (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .start_i  (tmr_start),
        .expire_o (tmr_expire)
    );

    assign busy_o = seq_q.busy;
    assign done_o = seq_q.done;
    assign err_o  = seq_q.err;

    // checker counter: cycles spent in the poll wait
    logic [WCW-1:0] wait_seen_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            wait_seen_q <= '0;
        end else if (seq_q.state == ST_WAIT) begin
            wait_seen_q <= wait_seen_q + 1'b1;
        end else begin
            wait_seen_q <= '0;
        end
    end

    // R6: the wait lasts the full interval
    assert_wait_len_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.state == ST_WAIT && seq_d.state != ST_WAIT) |-> (wait_seen_q == WCW'(WAIT_CYCLES - 1)));

    // R7: poll count never exceeds the limit
    assert_poll_bound_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        seq_q.polls <= PW'(MAX_POLLS));

    // R7: a locked status read leads straight to the enable write
    assert_lock_enables_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (seq_q.state == ST_POLL && acc_ack && acc_rdata[STS_LOCKED]) |=> (seq_q.state == ST_WR_EN));

    // R10: result pulses are exclusive and last one cycle
    assert_result_excl_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(done_o && err_o));
    assert_result_pulse_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (done_o || err_o) |=> !(done_o || err_o));

    // R10: busy falls only together with a result pulse
    assert_busy_end_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (done_o || err_o));

    // R11: busy only rises after a start pulse
    assert_busy_start_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(busy_o) |-> $past(start_i));

    // R9: no bus activity while idle
    assert_idle_quiet_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> !(reg_wr_o || reg_rd_o));

endmodule

// File: tb/tb_pll_reprog_seq.sv
`timescale 1ns/1ps
module tb_pll_reprog_seq;

    localparam int unsigned CLK_MHZ   = 2;
    localparam int unsigned POLL_US   = 10;
    localparam int unsigned MAX_POLLS = 4;
    localparam int unsigned ADDR_W    = 12;
    localparam int unsigned WAIT_CYC  = CLK_MHZ * POLL_US;

    localparam logic [ADDR_W-1:0] A_STATUS = 12'h01C;
    localparam logic [ADDR_W-1:0] A_CTRL   = 12'h020;
    localparam logic [ADDR_W-1:0] A_MULT   = 12'h024;
    localparam logic [ADDR_W-1:0] A_DIVS   = 12'h028;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [31:0]       cfg = '0;
    logic [ADDR_W-1:0] addr;
    logic [31:0]       wdata;
    logic              wr, rd;
    logic [31:0]       rdata = '0;
    logic              ready = 1'b0;
    logic              busy, done, err;

    always #2.5 clk = ~clk;

    pll_reprog_seq #(
        .CLK_FREQ_MHZ (CLK_MHZ),
        .POLL_US      (POLL_US),
        .MAX_POLLS    (MAX_POLLS),
        .ADDR_W       (ADDR_W)
    ) dut (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .start_i     (start),
        .cfg_word_i  (cfg),
        .reg_addr_o  (addr),
        .reg_wdata_o (wdata),
        .reg_wr_o    (wr),
        .reg_rd_o    (rd),
        .reg_rdata_i (rdata),
        .reg_ready_i (ready),
        .busy_o      (busy),
        .done_o      (done),
        .err_o       (err)
    );

    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit finished = 1'b0;

    // slave model state
    logic [31:0] m_ctrl;
    int          lock_after;
    int          polls_seen;
    int          n_log;
    bit          log_wr   [16];
    logic [ADDR_W-1:0] log_addr [16];
    logic [31:0] log_data [16];
    int          log_first[16];
    int          log_end  [16];
    int          n_done, n_err;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual 0x%08h expected 0x%08h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    // bus slave with random ready delay
    initial begin
        bit pending = 0;
        int delay = 0;
        int first_c = 0;
        logic [ADDR_W-1:0] first_a = '0;
        bit first_w = 0;
        forever begin
            @(negedge clk);
            if (ready) begin
                ready = 1'b0;
            end else if (wr || rd) begin
                if (wr && rd) chk(1'b0, "R9 both strobes", {30'd0, wr, rd}, 32'd1);
                if (!pending) begin
                    pending = 1;
                    first_c = cyc;
                    first_a = addr;
                    first_w = wr;
                    delay   = int'($urandom % 4);
                end
                if (delay == 0) begin
                    chk(addr == first_a && wr == first_w, "R9 held access",
                        {19'd0, wr, addr}, {19'd0, first_w, first_a});
                    if (!busy) chk(1'b0, "R10 busy during access", 32'd0, 32'd1);
                    if (n_log < 16) begin
                        log_wr[n_log]    = wr;
                        log_addr[n_log]  = addr;
                        log_data[n_log]  = wr ? wdata : 32'd0;
                        log_first[n_log] = first_c;
                        log_end[n_log]   = cyc;
                    end
                    n_log++;
                    if (wr) begin
                        if (addr == A_CTRL) m_ctrl = wdata;
                    end else if (addr == A_STATUS) begin
                        polls_seen++;
                        rdata = {$urandom, 1'b0} | 32'((lock_after != 0) && (polls_seen >= lock_after));
                        rdata = {rdata[31:1], rdata[0]};
                    end else if (addr == A_CTRL) begin
                        rdata = m_ctrl;
                    end else begin
                        rdata = $urandom;
                    end
                    ready   = 1'b1;
                    pending = 0;
                end else begin
                    delay--;
                end
            end
        end
    end

    // result monitor
    initial begin
        forever begin
            @(negedge clk);
            if (done) n_done++;
            if (err)  n_err++;
            if (done && err) chk(1'b0, "R10 exclusive results", 32'd3, 32'd1);
            if ((done || err) && busy) chk(1'b0, "R10 busy low with result", 32'd1, 32'd0);
        end
    end

    function automatic logic [31:0] exp_pd(input logic [31:0] c0);
        return (c0 | 32'h1) & ~32'h1E;
    endfunction

    task automatic run_seq(input logic [31:0] c_word, input logic [31:0] c0,
                           input int lk, input bit inject);
        int nd0, ne0, exp_polls, idx, wait_cnt;
        bit ok_seq;
        m_ctrl = c0;
        lock_after = lk;
        polls_seen = 0;
        n_log = 0;
        nd0 = n_done;
        ne0 = n_err;
        @(negedge clk);
        start = 1'b1;
        cfg   = c_word;
        @(negedge clk);
        start = 1'b0;
        cfg   = ~c_word;
        chk(busy == 1'b1, "R2 busy after start", {31'd0, busy}, 32'd1);
        if (inject) begin
            repeat (WAIT_CYC + 7) @(negedge clk);
            start = 1'b1;
            cfg   = c_word ^ 32'h5A5A_0F0F;
            @(negedge clk);
            start = 1'b0;
        end
        wait_cnt = 0;
        while ((n_done + n_err) == (nd0 + ne0) && wait_cnt < 3000) begin
            @(negedge clk);
            wait_cnt++;
        end
        chk(wait_cnt < 3000, "R10 sequence completes", wait_cnt, 0);
        repeat (WAIT_CYC + 10) @(negedge clk);
        chk((n_done - nd0) + (n_err - ne0) == 1, "R11 single result", (n_done - nd0) + (n_err - ne0), 1);
        chk(busy == 1'b0, "R10 busy cleared", {31'd0, busy}, 32'd0);

        exp_polls = (lk >= 1 && lk <= int'(MAX_POLLS)) ? lk : int'(MAX_POLLS);
        ok_seq    = (lk >= 1 && lk <= int'(MAX_POLLS));
        chk(n_log == 5 + exp_polls + (ok_seq ? 1 : 0), "R7 access count", n_log, 5 + exp_polls + (ok_seq ? 1 : 0));
        if (n_log < 5 + exp_polls) return;
        chk(!log_wr[0] && log_addr[0] == A_CTRL, "R2 first access reads control",
            {19'd0, log_wr[0], log_addr[0]}, {20'd0, A_CTRL});
        chk(log_wr[1] && log_addr[1] == A_CTRL && log_data[1] == exp_pd(c0), "R3 power-down write",
            log_data[1], exp_pd(c0));
        chk(log_wr[2] && log_addr[2] == A_MULT && log_data[2] == c_word, "R4 multiplier write",
            log_data[2], c_word);
        chk(log_wr[3] && log_addr[3] == A_DIVS && log_data[3] == 32'h0030_2062, "R4 divider write",
            log_data[3], 32'h0030_2062);
        chk(log_wr[4] && log_addr[4] == A_CTRL && log_data[4] == (c0 & ~32'h1F), "R5 power-up write",
            log_data[4], c0 & ~32'h1F);
        for (int i = 0; i < exp_polls; i++) begin
            idx = 5 + i;
            chk(!log_wr[idx] && log_addr[idx] == A_STATUS, "R6 status read",
                {19'd0, log_wr[idx], log_addr[idx]}, {20'd0, A_STATUS});
            chk(log_first[idx] - log_end[idx-1] >= int'(WAIT_CYC) + 2, "R6 wait before poll",
                log_first[idx] - log_end[idx-1], WAIT_CYC + 2);
        end
        if (ok_seq) begin
            idx = 5 + exp_polls;
            chk(log_wr[idx] && log_addr[idx] == A_CTRL && log_data[idx] == ((c0 & ~32'h1F) | 32'h10),
                "R7 enable write", log_data[idx], (c0 & ~32'h1F) | 32'h10);
            chk(n_done - nd0 == 1, "R7 done pulse", n_done - nd0, 1);
        end else begin
            chk(n_err - ne0 == 1, "R8 error pulse", n_err - ne0, 1);
            chk(m_ctrl[4] == 1'b0, "R8 enable stays clear", m_ctrl, c0 & ~32'h1F);
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        n_done = 0;
        n_err = 0;
        n_log = 0;
        polls_seen = 0;
        lock_after = 0;
        m_ctrl = '0;
        repeat (4) @(negedge clk);
        chk(!busy && !done && !err && !wr && !rd, "R1 reset state",
            {27'd0, busy, done, err, wr, rd}, 32'd0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!busy && !wr && !rd, "R1 idle after reset", {29'd0, busy, wr, rd}, 32'd0);

        // directed corners
        run_seq(32'h0001_2345, 32'hFFFF_FFFF, 1, 1'b0);   // R7 lock on first poll
        run_seq(32'hDEAD_BEEF, 32'h0000_0000, 4, 1'b0);   // R7 lock on last poll
        run_seq(32'h0000_00FF, 32'hA5A5_A5FE, 0, 1'b0);   // R8 never locks
        run_seq(32'h1357_9BDF, 32'h0F0F_0F1F, 5, 1'b0);   // R8 locks too late
        run_seq(32'h2468_ACE0, 32'h1234_5678, 2, 1'b1);   // R11 start while busy
        // random mix
        for (int k = 0; k < 10; k++) begin
            run_seq($urandom, $urandom, int'($urandom % 6), ($urandom % 3) == 0);
        end
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 5);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule